// File: doc/BRIEF.md
# PHY Test-Port Register Write Engine

This block drives the serial configuration port that a physical-layer macro exposes for programming its internal registers. The port has four wires toward the macro: a strobe, an operation-select line, an active-high clear and an 8-bit input bus. The block also takes in an 8-bit read-back bus from the macro. A single command carries an 8-bit register index and an 8-bit value. The engine turns each command into two strobe pulses. The first pulse has the select line high and the index on the bus, and the macro takes the index on the strobe's falling edge. The second pulse has the select line low and the value on the bus, and the macro takes the value on the strobe's rising edge.

A typical start-up programs the PLL by writing value 0x74 to index 0x44. Software issues one command per register and watches `busy` and `done`. When the data phase ends, the engine captures the read-back bus and raises `done` for one cycle. The clear line starts out asserted. It drops as soon as a command is accepted, and it can be raised again through `clear_req` while the engine is idle. The strobe high time and low time are each set by `half_period` in system clock cycles.

Top module: `tport_wr_engine`

## Requirements
- R1: After reset, `tp_clr` is 1. `tp_strobe`, `tp_sel`, `busy`, `done` and `overrun` are 0, and `tp_din` and `rd_data` are 0x00.
- R2: When `cmd_valid` is high at a clock edge while `busy` is 0, the command is accepted. From the next cycle `busy` is 1, `tp_clr` is 0, `tp_sel` is 1 and `tp_din` holds `cmd_code`, all for one cycle before the strobe first rises.
- R3: In the address phase, `tp_strobe` is high for N cycles and then low for N cycles. `tp_sel` stays 1 and `tp_din` stays at the code throughout, so the falling edge occurs with the select line high.
- R4: One cycle after the address phase, `tp_sel` goes to 0 and `tp_din` takes the value. One cycle later, `tp_strobe` is high for N cycles and then low for N cycles.
- R5: N equals `half_period` when that input is non-zero and equals 1 when it is zero. `half_period` is sampled only when a command is accepted.
- R6: The cycle after the data phase, `busy` is 0 and `done` is 1 for exactly one cycle. `rd_data` then holds `tp_dout` as sampled at the edge that ends the data phase. A command keeps `busy` high for 4N+2 cycles.
- R7: A `cmd_valid` that arrives while `busy` is 1 is ignored and sets `overrun`. The flag stays set until reset.
- R8: While idle, a high `clear_req` with no `cmd_valid` sets `tp_clr` to 1 from the next cycle. A `clear_req` while busy is ignored. If `cmd_valid` and `clear_req` are both high while idle, the command wins and `tp_clr` goes to 0.
- R9: `tp_sel` and `tp_din` never change at the same edge where `tp_strobe` rises or falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_code | input | 8 | Register index of the command |
| cmd_value | input | 8 | Value to write |
| half_period | input | 8 | Strobe level length in cycles (0 means 1) |
| clear_req | input | 1 | Request to assert the port clear while idle |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| overrun | output | 1 | Sticky: a command arrived while busy |
| rd_data | output | 8 | Read-back byte captured at completion |
| tp_strobe | output | 1 | Port strobe |
| tp_sel | output | 1 | Port operation select (1 = index, 0 = value) |
| tp_clr | output | 1 | Port clear, active high |
| tp_din | output | 8 | Port input bus |
| tp_dout | input | 8 | Port read-back bus |

## Verification
The hardest situations to reach are requests that arrive in the middle of a transaction: a second command, or a clear request, landing while the strobe is partway through its address phase. The bench injects these at a chosen cycle offset inside an ongoing write. It then checks that the waveform continues unchanged, that the stray index never reaches the macro, and that only `overrun` records the event. A zero `half_period`, and a `half_period` that changes right after acceptance, are driven into the same cycle-exact waveform checker. A small model of the macro latches indices on falling strobe edges and values on rising strobe edges. This model lets the edge polarity be checked end to end through the read-back bus.

// File: rtl/tport_pkg.sv
package tport_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ASET,
    ST_AHI,
    ST_ALO,
    ST_DSET,
    ST_DHI,
    ST_DLO
  } tp_state_e;
endpackage

// File: rtl/tport_timer.sv
module tport_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = len_i - CW'(1);
    else if (cnt_q != '0)    cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == '0);

  // a zero-length level would underflow the counter
  assert_len_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (len_i != '0));
endmodule

// File: rtl/tport_capture.sv
module tport_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take_i,
  input  logic [DW-1:0] dout_i,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o
);
  logic [DW-1:0] rd_q;
  logic          done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= take_i;
      if (take_i) rd_q <= dout_i;
    end
  end

  assign rd_data_o = rd_q;
  assign done_o    = done_q;

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/tport_seq.sv
module tport_seq
  import tport_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid_i,
  input  logic [DW-1:0] cmd_code_i,
  input  logic [DW-1:0] cmd_value_i,
  input  logic [CW-1:0] half_i,
  input  logic          clear_req_i,
  input  logic          expire_i,
  output logic          load_o,
  output logic [CW-1:0] len_o,
  output logic          take_o,
  output logic          busy_o,
  output logic          overrun_o,
  output logic          strobe_o,
  output logic          sel_o,
  output logic          clr_o,
  output logic [DW-1:0] din_o
);
  tp_state_e     st_q, st_d;
  logic          sel_q, sel_d;
  logic          clr_q, clr_d;
  logic          ovr_q, ovr_d;
  logic          strb_q, strb_d;
  logic [DW-1:0] din_q, din_d;
  logic [DW-1:0] val_q, val_d;
  logic [CW-1:0] len_q, len_d;

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    clr_d  = clr_q;
    ovr_d  = ovr_q;
    din_d  = din_q;
    val_d  = val_q;
    len_d  = len_q;
    load_o = 1'b0;
    take_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (cmd_valid_i) begin
          st_d  = ST_ASET;
          sel_d = 1'b1;
          din_d = cmd_code_i;
          val_d = cmd_value_i;
          len_d = (half_i == '0) ? CW'(1) : half_i;
          clr_d = 1'b0;
        end else if (clear_req_i) begin
          clr_d = 1'b1;
        end
      end
      ST_ASET: begin
        st_d   = ST_AHI;
        load_o = 1'b1;
      end
      ST_AHI: begin
        if (expire_i) begin
          st_d   = ST_ALO;
          load_o = 1'b1;
        end
      end
      ST_ALO: begin
        if (expire_i) begin
          st_d  = ST_DSET;
          sel_d = 1'b0;
          din_d = val_q;
        end
      end
      ST_DSET: begin
        st_d   = ST_DHI;
        load_o = 1'b1;
      end
      ST_DHI: begin
        if (expire_i) begin
          st_d   = ST_DLO;
          load_o = 1'b1;
        end
      end
      ST_DLO: begin
        if (expire_i) begin
          st_d   = ST_IDLE;
          take_o = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if ((st_q != ST_IDLE) && cmd_valid_i) ovr_d = 1'b1;
    strb_d = (st_d == ST_AHI) || (st_d == ST_DHI);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sel_q  <= 1'b0;
      clr_q  <= 1'b1;
      ovr_q  <= 1'b0;
      strb_q <= 1'b0;
      din_q  <= '0;
      val_q  <= '0;
      len_q  <= CW'(1);
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      clr_q  <= clr_d;
      ovr_q  <= ovr_d;
      strb_q <= strb_d;
      din_q  <= din_d;
      val_q  <= val_d;
      len_q  <= len_d;
    end
  end

  assign len_o     = len_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign overrun_o = ovr_q;
  assign strobe_o  = strb_q;
  assign sel_o     = sel_q;
  assign clr_o     = clr_q;
  assign din_o     = din_q;

  assert_setup_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_q) |-> ($stable(sel_q) && $stable(din_q)));
  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strb_q) |-> ($stable(sel_q) && $stable(din_q)));
  assert_clr_low_strobing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    strb_q |-> !clr_q);
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !strb_q);
endmodule

// File: rtl/tport_wr_engine.sv
module tport_wr_engine #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [DW-1:0] cmd_code,
  input  logic [DW-1:0] cmd_value,
  input  logic [CW-1:0] half_period,
  input  logic          clear_req,
  output logic          busy,
  output logic          done,
  output logic          overrun,
  output logic [DW-1:0] rd_data,
  output logic          tp_strobe,
  output logic          tp_sel,
  output logic          tp_clr,
  output logic [DW-1:0] tp_din,
  input  logic [DW-1:0] tp_dout
);
  logic          load_w, expire_w, take_w;
  logic [CW-1:0] len_w;

  tport_seq #(.DW(DW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code), .cmd_value_i(cmd_value),
    .half_i(half_period), .clear_req_i(clear_req), .expire_i(expire_w),
    .load_o(load_w), .len_o(len_w), .take_o(take_w),
    .busy_o(busy), .overrun_o(overrun),
    .strobe_o(tp_strobe), .sel_o(tp_sel), .clr_o(tp_clr), .din_o(tp_din)
  );

  tport_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n),
    .load_i(load_w), .len_i(len_w), .expire_o(expire_w)
  );

  tport_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n),
    .take_i(take_w), .dout_i(tp_dout),
    .rd_data_o(rd_data), .done_o(done)
  );

  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: tb/sim_tport_wr_engine.sv
module sim_tport_wr_engine;
  logic       clk, rst_n;
  logic       cmd_valid, clear_req;
  logic [7:0] cmd_code, cmd_value, half_period;
  logic       busy, done, overrun, tp_strobe, tp_sel, tp_clr;
  logic [7:0] rd_data, tp_din, tp_dout;

  int nvec = 0;
  int nerr = 0;
  bit fin  = 0;

  logic [7:0] m_reg [256];
  logic [7:0] m_addr;

  tport_wr_engine u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_value(cmd_value), .half_period(half_period), .clear_req(clear_req),
    .busy(busy), .done(done), .overrun(overrun), .rd_data(rd_data),
    .tp_strobe(tp_strobe), .tp_sel(tp_sel), .tp_clr(tp_clr),
    .tp_din(tp_din), .tp_dout(tp_dout)
  );

  initial clk = 1'b0;
  always #5ns clk = ~clk;

  // macro model: index on falling strobe (select high), value on rising (select low)
  always @(negedge tp_strobe) if (tp_sel === 1'b1 && tp_clr === 1'b0) m_addr <= tp_din;
  always @(posedge tp_strobe) if (tp_sel === 1'b0 && tp_clr === 1'b0) m_reg[m_addr] <= tp_din;
  assign tp_dout = m_reg[m_addr];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_write(input logic [7:0] code, input logic [7:0] val, input int hp,
                           input int inj_c, input bit inj_clr);
    int n;
    n = (hp == 0) ? 1 : hp;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_value = val; half_period = 8'(hp);
    for (int c = 1; c <= 4*n+3; c++) begin
      logic e_busy, e_done, e_strb, e_sel;
      logic [7:0] e_din;
      @(negedge clk);
      cmd_valid = 1'b0; clear_req = 1'b0;
      if (c == 1) half_period = 8'(hp + 5);  // R5: change after acceptance has no effect
      e_busy = (c <= 4*n+2);
      e_done = (c == 4*n+3);
      e_strb = (c >= 2 && c <= n+1) || (c >= 2*n+3 && c <= 3*n+2);
      e_sel  = (c <= 2*n+1);
      e_din  = (c <= 2*n+1) ? code : val;
      chk({busy, done, tp_strobe, tp_sel, tp_clr, tp_din} === {e_busy, e_done, e_strb, e_sel, 1'b0, e_din},
          "R2 R3 R4 R5 R8 R9 waveform {busy,done,strb,sel,clr,din}",
          {19'd0, busy, done, tp_strobe, tp_sel, tp_clr, tp_din},
          {19'd0, e_busy, e_done, e_strb, e_sel, 1'b0, e_din});
      if (e_done) chk(rd_data === val, "R6 read-back", {24'd0, rd_data}, {24'd0, val});
      if (c == inj_c) begin
        if (inj_clr) clear_req = 1'b1;
        else begin cmd_valid = 1'b1; cmd_code = 8'hEE; cmd_value = 8'h11; end
      end
    end
    chk(m_reg[code] === val, "R3 R4 macro register written", {24'd0, m_reg[code]}, {24'd0, val});
  endtask

  task automatic t_reset;
    chk({tp_clr, tp_strobe, tp_sel, busy, done, overrun} === 6'b100000, "R1 control outputs",
        {26'd0, tp_clr, tp_strobe, tp_sel, busy, done, overrun}, 32'h20);
    chk({tp_din, rd_data} === 16'h0, "R1 buses", {16'd0, tp_din, rd_data}, 32'h0);
  endtask

  task automatic t_writes;
    run_write(8'h44, 8'h74, 1, 0, 1'b0);
    run_write(8'h12, 8'hA5, 3, 0, 1'b0);
    run_write(8'h07, 8'h3C, 0, 0, 1'b0);  // R5: zero acts as one
    chk(overrun === 1'b0, "R7 no overrun yet", {31'd0, overrun}, 32'h0);
  endtask

  task automatic t_overrun;
    run_write(8'h3C, 8'h5A, 2, 3, 1'b0);
    @(negedge clk);
    chk(overrun === 1'b1, "R7 overrun set", {31'd0, overrun}, 32'h1);
    chk(m_reg[8'hEE] === 8'h00, "R7 stray command ignored", {24'd0, m_reg[8'hEE]}, 32'h0);
    run_write(8'h21, 8'h99, 1, 0, 1'b0);
    chk(overrun === 1'b1, "R7 overrun sticky", {31'd0, overrun}, 32'h1);
  endtask

  task automatic t_clear;
    @(negedge clk);
    clear_req = 1'b1;
    @(negedge clk);
    clear_req = 1'b0;
    chk(tp_clr === 1'b1 && busy === 1'b0, "R8 idle clear asserted", {30'd0, tp_clr, busy}, 32'h2);
    run_write(8'h50, 8'h0F, 2, 4, 1'b1);   // clear request while busy ignored
    @(negedge clk);
    chk(tp_clr === 1'b0, "R8 clear while busy ignored", {31'd0, tp_clr}, 32'h0);
    clear_req = 1'b1;                        // held into the next accept: command wins
    run_write(8'h51, 8'hF0, 1, 0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_reg[i] = 8'h00;
    m_addr = 8'h00;
    rst_n = 1'b0; cmd_valid = 1'b0; clear_req = 1'b0;
    cmd_code = 8'h00; cmd_value = 8'h00; half_period = 8'h01;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_writes;
    t_overrun;
    t_clear;
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #1ms;
    if (!fin) begin
      nvec++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule